// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a synchronous, SDRAM-style flash bus and watches the stream of bus write cycles. It recognises multi-cycle unlock sequences and turns each complete sequence into a single internal action. The actions are a one-cycle program strobe with target address and data, a one-cycle erase strobe with a sector number, a one-cycle boot lock strobe, and a registered read-mode selector that steers later reads to the array, the identification codes or the lock status byte. Bus cycles that carry no write, such as a precharge or an idle slot, are not part of any sequence and leave it untouched.

Every sequence opens with two unlock writes: data AA at key address 555h, then data 55 at key address 2AAh. Only the low byte of the data bus takes part in key comparison. The third write picks the command. A0 leads to a program target cycle. 90 enters identification read mode. F0 returns to array read mode. 80 opens an extended branch that needs a second key pair. That branch then ends in boot lock, sector erase or lock-status read. Any write that does not fit the sequence sends the decoder back to idle and discards what was collected so far.

The state machine has seven states. S_IDLE waits for the first key. S_GOT_AA waits for the second key. S_GOT_55 waits for the command byte. S_PGM_TGT waits for the program target. S_EXT_AA waits for the extended first key. S_EXT_SEL waits for either 55 or the lock byte. S_EXT_FIN waits for the erase confirm or the verify byte. The forward transitions are IDLE→GOT_AA on AA@555, GOT_AA→GOT_55 on 55@2AA, GOT_55→PGM_TGT on A0@555, GOT_55→EXT_AA on 80@555, EXT_AA→EXT_SEL on AA@555, and EXT_SEL→EXT_FIN on 55@2AA. Every other write returns the machine to S_IDLE, and the actions below fire on some of those returns. GOT_55 fires ident entry on 90@555 and exit on F0@555. PGM_TGT fires program on any write. EXT_SEL fires lock on 40@555. EXT_FIN fires lock-status mode on 90@555, and fires erase on data 30 at any other address.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset all strobes are low, `rd_mode` is 0 (array), `boot_locked` is 0 and `lock_code` is 00h.
- R2: The writes AA@555h, 55@2AAh, A0@555h, then any address/data raise `pgm_strobe` for one cycle, starting the cycle after the fourth write. In that cycle `pgm_addr`/`pgm_data` hold the fourth write's address and data.
- R3: The writes AA@555h, 55@2AAh, 80@555h, AA@555h, 55@2AAh, then data 30h at any address other than a verify match raise `erase_strobe` for one cycle. `erase_sector` equals the top log2(SECTORS) address bits of the sixth write.
- R4: AA@555h, 55@2AAh, 90@555h sets `rd_mode` to 1 (identification). AA@555h, 55@2AAh, F0@555h sets it to 0 (array). The value 3 never appears.
- R5: AA@555h, 55@2AAh, 80@555h, AA@555h, 40@555h raises `lock_strobe` for one cycle. `boot_locked` is 1 from that same cycle on.
- R6: AA@555h, 55@2AAh, 80@555h, AA@555h, 55@2AAh, 90@555h sets `rd_mode` to 2 (lock status). `lock_code` reads 00h while unlocked and 01h while locked.
- R7: Cycles with `wr_valid` low, whether idle or precharge, do not advance, break or restart a sequence.
- R8: A write that does not match the expected key or command returns the decoder to idle with no strobe. The mismatching write does not itself start a new sequence.
- R9: While `boot_locked` is 1, a program to an address below BOOT_WORDS and an erase of sector 0 produce no strobe. Program and erase elsewhere still work.
- R10: `boot_locked` never falls except by reset, and a repeated lock command leaves it set.
- R11: At most one of the three strobes is high in any cycle, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A bus write cycle is present |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; low byte compared against keys |
| pgm_strobe | output | 1 | One-cycle program request |
| pgm_addr | output | AW | Program target address |
| pgm_data | output | DW | Program data |
| erase_strobe | output | 1 | One-cycle sector erase request |
| erase_sector | output | log2(SECTORS) | Sector to erase |
| lock_strobe | output | 1 | One-cycle boot lock request |
| boot_locked | output | 1 | Boot region lock state |
| rd_mode | output | 2 | 0 array, 1 identification, 2 lock status |
| lock_code | output | 8 | Lock status byte, 00h or 01h |

## Verification
The bench builds the decoder with a 12-bit address, 16-bit data, eight sectors and a 64-word boot region. This keeps both key addresses inside the address range and makes sector numbers come from bits 11:9. Boot and non-boot program targets, as well as sector 0 and other sectors, can then be reached with short literal addresses. A behavioural queue model of the key sequences runs alongside and is compared on every clock. Random writes drawn mostly from the key set reach partial sequences, mismatches at every depth, and locked and unlocked drops.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_GOT_AA  = 3'd1,
        S_GOT_55  = 3'd2,
        S_PGM_TGT = 3'd3,
        S_EXT_AA  = 3'd4,
        S_EXT_SEL = 3'd5,
        S_EXT_FIN = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        RD_ARRAY    = 2'd0,
        RD_IDENT    = 2'd1,
        RD_LOCKSTAT = 2'd2
    } rd_mode_e;

    localparam logic [7:0] KEY_FIRST   = 8'hAA;
    localparam logic [7:0] KEY_SECOND  = 8'h55;
    localparam logic [7:0] CMD_PROGRAM = 8'hA0;
    localparam logic [7:0] CMD_EXTEND  = 8'h80;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_EXIT    = 8'hF0;
    localparam logic [7:0] CMD_LOCK    = 8'h40;
    localparam logic [7:0] CMD_ERASE   = 8'h30;

    // Key matcher index map
    localparam int KM_FIRST  = 0;
    localparam int KM_SECOND = 1;
    localparam int KM_PGM    = 2;
    localparam int KM_EXT    = 3;
    localparam int KM_IDENT  = 4;
    localparam int KM_EXIT   = 5;
    localparam int KM_LOCK   = 6;
    localparam int KM_COUNT  = 7;

endpackage

// File: rtl/fsd_key_match.sv
module fsd_key_match #(
    parameter int              AW    = 21,
    parameter logic [AW-1:0]   KADDR = '0,
    parameter logic [7:0]      KDATA = '0
) (
    input  logic [AW-1:0] addr,
    input  logic [7:0]    data,
    output logic          hit
);
    assign hit = (addr == KADDR) && (data == KDATA);
endmodule

// File: rtl/fsd_boot_guard.sv
module fsd_boot_guard #(
    parameter int AW         = 21,
    parameter int SEC_W      = 3,
    parameter int BOOT_WORDS = 8192
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_lock,
    input  logic [AW-1:0] tgt_addr,
    output logic          locked,
    output logic          pgm_block,
    output logic          erase_block
);
    localparam logic [AW-1:0] BOOT_LIMIT = AW'(BOOT_WORDS);

    logic locked_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
        end else if (set_lock) begin
            locked_q <= 1'b1;
        end
    end

    assign locked      = locked_q;
    assign pgm_block   = locked_q && (tgt_addr < BOOT_LIMIT);
    assign erase_block = locked_q && (tgt_addr[AW-1 -: SEC_W] == '0);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_seq_pkg::*;
#(
    parameter int AW         = 21,
    parameter int DW         = 16,
    parameter int SECTORS    = 8,
    parameter int BOOT_WORDS = 8192,
    parameter int KEY_ADDR_A = 'h555,
    parameter int KEY_ADDR_B = 'h2AA,
    localparam int SEC_W     = $clog2(SECTORS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic             pgm_strobe,
    output logic [AW-1:0]    pgm_addr,
    output logic [DW-1:0]    pgm_data,
    output logic             erase_strobe,
    output logic [SEC_W-1:0] erase_sector,
    output logic             lock_strobe,
    output logic             boot_locked,
    output logic [1:0]       rd_mode,
    output logic [7:0]       lock_code
);
    localparam logic [7:0] KDATA [KM_COUNT] = '{
        KEY_FIRST, KEY_SECOND, CMD_PROGRAM, CMD_EXTEND, CMD_IDENT, CMD_EXIT, CMD_LOCK
    };
    localparam logic [KM_COUNT-1:0] USE_ADDR_B = KM_COUNT'(1) << KM_SECOND;

    seq_state_e st_q, st_d;
    rd_mode_e   mode_q;
    logic [KM_COUNT-1:0] khit;
    logic do_pgm, do_erase, do_lock, do_ident, do_exit, do_verify;
    logic pgm_blk, erase_blk, locked;

    for (genvar k = 0; k < KM_COUNT; k++) begin : g_key
        fsd_key_match #(
            .AW    (AW),
            .KADDR (USE_ADDR_B[k] ? AW'(KEY_ADDR_B) : AW'(KEY_ADDR_A)),
            .KDATA (KDATA[k])
        ) u_km (
            .addr (wr_addr),
            .data (wr_data[7:0]),
            .hit  (khit[k])
        );
    end

    fsd_boot_guard #(
        .AW         (AW),
        .SEC_W      (SEC_W),
        .BOOT_WORDS (BOOT_WORDS)
    ) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_lock    (do_lock),
        .tgt_addr    (wr_addr),
        .locked      (locked),
        .pgm_block   (pgm_blk),
        .erase_block (erase_blk)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and command decode
    always_comb begin
        st_d      = st_q;
        do_pgm    = 1'b0;
        do_erase  = 1'b0;
        do_lock   = 1'b0;
        do_ident  = 1'b0;
        do_exit   = 1'b0;
        do_verify = 1'b0;
        if (wr_valid) begin
            unique case (st_q)
                S_IDLE:    st_d = khit[KM_FIRST]  ? S_GOT_AA : S_IDLE;
                S_GOT_AA:  st_d = khit[KM_SECOND] ? S_GOT_55 : S_IDLE;
                S_GOT_55: begin
                    st_d = S_IDLE;
                    if (khit[KM_PGM])        st_d = S_PGM_TGT;
                    else if (khit[KM_EXT])   st_d = S_EXT_AA;
                    else if (khit[KM_IDENT]) do_ident = 1'b1;
                    else if (khit[KM_EXIT])  do_exit  = 1'b1;
                end
                S_PGM_TGT: begin
                    st_d   = S_IDLE;
                    do_pgm = 1'b1;
                end
                S_EXT_AA:  st_d = khit[KM_FIRST] ? S_EXT_SEL : S_IDLE;
                S_EXT_SEL: begin
                    st_d = S_IDLE;
                    if (khit[KM_SECOND])    st_d    = S_EXT_FIN;
                    else if (khit[KM_LOCK]) do_lock = 1'b1;
                end
                S_EXT_FIN: begin
                    st_d = S_IDLE;
                    if (khit[KM_IDENT])                  do_verify = 1'b1;
                    else if (wr_data[7:0] == CMD_ERASE)  do_erase  = 1'b1;
                end
                default:   st_d = S_IDLE;
            endcase
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pgm_strobe   <= 1'b0;
            pgm_addr     <= '0;
            pgm_data     <= '0;
            erase_strobe <= 1'b0;
            erase_sector <= '0;
            lock_strobe  <= 1'b0;
            mode_q       <= RD_ARRAY;
        end else begin
            pgm_strobe   <= do_pgm & ~pgm_blk;
            erase_strobe <= do_erase & ~erase_blk;
            lock_strobe  <= do_lock;
            if (do_pgm && !pgm_blk) begin
                pgm_addr <= wr_addr;
                pgm_data <= wr_data;
            end
            if (do_erase && !erase_blk) begin
                erase_sector <= wr_addr[AW-1 -: SEC_W];
            end
            if (do_ident)       mode_q <= RD_IDENT;
            else if (do_exit)   mode_q <= RD_ARRAY;
            else if (do_verify) mode_q <= RD_LOCKSTAT;
        end
    end

    assign boot_locked = locked;
    assign rd_mode     = mode_q;
    assign lock_code   = {7'b0, locked};
endmodule

// File: rtl/fsd_checker.sv
module fsd_checker #(
    parameter int AW         = 21,
    parameter int SEC_W      = 3,
    parameter int BOOT_WORDS = 8192
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pgm_strobe,
    input logic [AW-1:0]    pgm_addr,
    input logic             erase_strobe,
    input logic [SEC_W-1:0] erase_sector,
    input logic             lock_strobe,
    input logic             boot_locked,
    input logic [1:0]       rd_mode
);
    assert_strobe_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_strobe, erase_strobe, lock_strobe}));

    assert_pgm_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_strobe |=> !pgm_strobe);

    assert_erase_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        erase_strobe |=> !erase_strobe);

    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        boot_locked |=> boot_locked);

    assert_lock_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_strobe |-> boot_locked);

    assert_pgm_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_strobe |-> !($past(boot_locked) && (pgm_addr < AW'(BOOT_WORDS))));

    assert_erase_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_strobe |-> !($past(boot_locked) && (erase_sector == '0)));

    assert_mode_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mode != 2'd3);
endmodule

bind flash_cmd_decoder fsd_checker #(
    .AW         (AW),
    .SEC_W      (SEC_W),
    .BOOT_WORDS (BOOT_WORDS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pgm_strobe   (pgm_strobe),
    .pgm_addr     (pgm_addr),
    .erase_strobe (erase_strobe),
    .erase_sector (erase_sector),
    .lock_strobe  (lock_strobe),
    .boot_locked  (boot_locked),
    .rd_mode      (rd_mode)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    localparam int PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int SECTORS = 8;
    localparam int SEC_W = 3;
    localparam int BOOT_WORDS = 64;
    localparam logic [AW-1:0] KA = 12'h555;
    localparam logic [AW-1:0] KB = 12'h2AA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic pgm_strobe, erase_strobe, lock_strobe, boot_locked;
    logic [AW-1:0] pgm_addr;
    logic [DW-1:0] pgm_data;
    logic [SEC_W-1:0] erase_sector;
    logic [1:0] rd_mode;
    logic [7:0] lock_code;

    int checks = 0;
    int fails = 0;
    string phase = "R1";

    // Reference model state
    logic [7:0] hq[$];
    bit m_pgm, m_erase, m_lock, m_locked;
    logic [AW-1:0] m_paddr;
    logic [DW-1:0] m_pdata;
    int m_sector, m_mode;

    always #(PERIOD/2) clk = ~clk;

    flash_cmd_decoder #(
        .AW(AW), .DW(DW), .SECTORS(SECTORS), .BOOT_WORDS(BOOT_WORDS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .pgm_strobe(pgm_strobe), .pgm_addr(pgm_addr),
        .pgm_data(pgm_data), .erase_strobe(erase_strobe),
        .erase_sector(erase_sector), .lock_strobe(lock_strobe),
        .boot_locked(boot_locked), .rd_mode(rd_mode), .lock_code(lock_code)
    );

    task automatic model_reset();
        hq.delete();
        m_pgm = 0; m_erase = 0; m_lock = 0; m_locked = 0;
        m_paddr = '0; m_pdata = '0; m_sector = 0; m_mode = 0;
    endtask

    task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] dfull);
        logic [7:0] d;
        bit keep;
        d = dfull[7:0];
        keep = 0;
        case (hq.size())
            0: keep = (a == KA && d == 8'hAA);
            1: keep = (a == KB && d == 8'h55);
            2: begin
                if (a == KA && (d == 8'hA0 || d == 8'h80)) keep = 1;
                else if (a == KA && d == 8'h90) m_mode = 1;
                else if (a == KA && d == 8'hF0) m_mode = 0;
            end
            3: begin
                if (hq[2] == 8'hA0) begin
                    m_pgm = 1;
                    if (m_locked && a < AW'(BOOT_WORDS)) m_pgm = 0;
                    if (m_pgm) begin m_paddr = a; m_pdata = dfull; end
                end else begin
                    keep = (a == KA && d == 8'hAA);
                end
            end
            4: begin
                if (a == KB && d == 8'h55) keep = 1;
                else if (a == KA && d == 8'h40) begin m_lock = 1; m_locked = 1; end
            end
            5: begin
                if (a == KA && d == 8'h90) m_mode = 2;
                else if (d == 8'h30) begin
                    if (!(m_locked && (a >> (AW - SEC_W)) == 0)) begin
                        m_erase = 1;
                        m_sector = int'(a >> (AW - SEC_W));
                    end
                end
            end
            default: keep = 0;
        endcase
        if (keep) hq.push_back(d);
        else hq.delete();
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (%s) %s: actual %0h expected %0h at %0t", req, phase, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2", "pgm_strobe", pgm_strobe, m_pgm);
        if (m_pgm) begin
            chk("R2", "pgm_addr", pgm_addr, m_paddr);
            chk("R2", "pgm_data", pgm_data, m_pdata);
        end
        chk("R3", "erase_strobe", erase_strobe, m_erase);
        if (m_erase) chk("R3", "erase_sector", erase_sector, m_sector);
        chk("R5", "lock_strobe", lock_strobe, m_lock);
        chk("R10", "boot_locked", boot_locked, m_locked);
        chk("R4", "rd_mode", rd_mode, m_mode);
        chk("R6", "lock_code", lock_code, m_locked ? 8'h01 : 8'h00);
        chk("R11", "strobe_count", pgm_strobe + erase_strobe + lock_strobe, m_pgm + m_erase + m_lock);
    endtask

    task automatic tick(input bit v, input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_valid = v; wr_addr = a; wr_data = d;
        @(posedge clk);
        m_pgm = 0; m_erase = 0; m_lock = 0;
        if (!rst_n) model_reset();
        else if (v) model_write(a, d);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        tick(1'b1, a, d);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, $urandom, $urandom);
    endtask

    task automatic unlock();
        wr(KA, 16'h00AA); wr(KB, 16'h0055);
    endtask

    task automatic do_program(input logic [AW-1:0] a, input logic [DW-1:0] d);
        unlock(); wr(KA, 16'h00A0); wr(a, d);
    endtask

    task automatic do_extend();
        unlock(); wr(KA, 16'h0080); wr(KA, 16'h00AA);
    endtask

    task automatic do_erase(input logic [AW-1:0] a);
        do_extend(); wr(KB, 16'h0055); wr(a, 16'h0030);
    endtask

    task automatic do_lock();
        do_extend(); wr(KA, 16'h0040);
    endtask

    task automatic do_verify();
        do_extend(); wr(KB, 16'h0055); wr(KA, 16'h0090);
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        // R1: reset state
        phase = "R1";
        nop(3);
        chk("R1", "rd_mode_reset", rd_mode, 0);
        chk("R1", "lock_code_reset", lock_code, 0);
        rst_n = 1'b1;
        nop(2);

        // R2 and R7: program with idle/precharge slots between the cycles
        phase = "R7";
        wr(KA, 16'h00AA); nop(2); wr(KB, 16'h0055); nop(1);
        wr(KA, 16'h00A0); nop(3); wr(12'h123, 16'hBEEF);
        chk("R2", "pgm_seen", pgm_strobe, 1);
        nop(1);
        phase = "R2";
        do_program(12'hFFF, 16'h1234);
        nop(1);

        // R3: erase sector 5
        phase = "R3";
        do_erase(12'hA10);
        chk("R3", "sector5", erase_sector, 5);
        nop(1);

        // R4: ident entry and exit
        phase = "R4";
        unlock(); wr(KA, 16'h0090);
        chk("R4", "ident_mode", rd_mode, 1);
        unlock(); wr(KA, 16'h00F0);
        chk("R4", "array_mode", rd_mode, 0);

        // R6: verify while unlocked
        phase = "R6";
        do_verify();
        chk("R6", "unlocked_code", lock_code, 8'h00);
        chk("R6", "lockstat_mode", rd_mode, 2);

        // R8: mismatches at several depths, then a clean program
        phase = "R8";
        unlock(); wr(KA, 16'h0077);
        wr(KA, 16'h00AA); wr(KB, 16'h0054);
        do_extend(); wr(KA, 16'h00AB);
        wr(KB, 16'h0055); wr(KA, 16'h00A0); wr(12'h200, 16'h0001);
        chk("R8", "no_strobe", pgm_strobe, 0);
        do_program(12'h321, 16'h5A5A);

        // R9: boot program before lock works
        phase = "R9";
        do_program(12'h010, 16'h0F0F);
        chk("R9", "boot_pgm_unlocked", pgm_strobe, 1);

        // R5: lock, then verify code
        phase = "R5";
        do_lock();
        chk("R5", "locked", boot_locked, 1);
        do_verify();
        chk("R6", "locked_code", lock_code, 8'h01);

        // R9: drops while locked
        phase = "R9";
        do_program(12'h010, 16'hAAAA);
        chk("R9", "boot_pgm_dropped", pgm_strobe, 0);
        do_program(12'h400, 16'hCCCC);
        chk("R9", "array_pgm_ok", pgm_strobe, 1);
        do_erase(12'h0FF);
        chk("R9", "sector0_dropped", erase_strobe, 0);
        do_erase(12'hE00);
        chk("R9", "sector7_ok", erase_strobe, 1);

        // R10: repeated lock keeps it set
        phase = "R10";
        do_lock();
        nop(2);
        chk("R10", "still_locked", boot_locked, 1);

        // R11: random traffic mostly from the key set
        phase = "R11";
        for (int i = 0; i < 3000; i++) begin
            int pick = $urandom_range(0, 11);
            case (pick)
                0, 1: wr(KA, 16'h00AA);
                2:    wr(KB, 16'h0055);
                3:    wr(KA, 16'h00A0);
                4:    wr(KA, 16'h0080);
                5:    wr(KA, 16'h0090);
                6:    wr(KA, 16'h00F0);
                7:    wr(KA, 16'h0040);
                8:    wr($urandom, 16'h0030);
                9:    wr($urandom, $urandom);
                default: nop(1);
            endcase
            if (i == 1500) begin
                rst_n = 1'b0; nop(1); rst_n = 1'b1;
            end
        end

        // R10: reset clears the lock
        phase = "R10";
        rst_n = 1'b0; nop(2);
        chk("R10", "reset_clears", boot_locked, 0);
        rst_n = 1'b1; nop(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule